// File: doc/BRIEF.md
# Configurable External Interrupt Pin Detector

This block monitors a single external interrupt-request pin. It keeps a latched status flag and drives an interrupt request from that flag. Software sets the block up with one register write. The settings are: whether the pin is used at all, which polarity counts as active, whether only transitions count or a held active level counts too, and whether a detected event raises the interrupt or only sets a flag for polling. The same write can also carry an acknowledge that clears the flag.

In run mode the pin is resynchronized to the system clock, and events are found by comparing two consecutive synchronized samples. In stop mode, the clock may be gated, so a purely combinational path from the raw pin drives a wake output. A read port returns the control settings, the flag and the synchronized pin level. A pull-select output tells the pad whether it should pull down instead of up.

Top module: `extIrqDetect`

## Requirements
- R1: After reset all control bits read 0, and the flag, interrupt request, wake and pull-select outputs are 0.
- R2: While the pin-enable bit (write data bit 3) is 0, no pin activity sets the flag, and the pin-level read bit reads 0.
- R3: The polarity bit (write data bit 2) selects the active condition: 1 means rising edges and high level, 0 means falling edges and low level.
- R4: In edge-only mode (write data bit 1 = 0), the flag sets when the pin moves into its active level. The flag is visible on the third rising clock edge after the pin change. An acknowledge while the level is still held clears the flag, and the flag stays clear.
- R5: In edge-and-level mode (write data bit 1 = 1), the flag sets whenever the synchronized pin is at its active level. An acknowledge has no effect while that level persists.
- R6: The interrupt request equals the flag ANDed with the interrupt-enable bit (write data bit 0). The flag sets regardless of interrupt-enable.
- R7: A write with data bit 4 = 1 acknowledges and clears the flag. A later event sets it again.
- R8: When an acknowledge and a newly detected edge occur on the same clock edge, the flag stays set.
- R9: The wake output is high exactly when the stop-mode input is 1, pin-enable is 1 and the raw pin is at its active level. It needs no clock.
- R10: The pull-select output is 1 (pulldown requested) exactly when pin-enable and the polarity bit are both 1.
- R11: The read data holds the four control bits in bits 3:0, the flag in bit 5 and the pin level in bit 6. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinRaw | input | 1 | External interrupt pin, asynchronous |
| stopMode | input | 1 | High while the chip is in stop mode |
| regWrite | input | 1 | Write strobe for the control register |
| regWdata | input | 8 | Write data: control bits and acknowledge |
| regRdata | output | 8 | Read data: control, flag, pin level |
| irqOut | output | 1 | Interrupt request |
| wakeOut | output | 1 | Asynchronous wake request |
| pullDown | output | 1 | Pad pull select, 1 = pulldown |

## Verification
Assertions check on every cycle that a disabled pin never sets a clear flag and that a held active level in level mode keeps the flag set. They also check that an edge-mode flag rise follows a change in the synchronized samples, that the request implies the enable, and that wake implies stop mode. The bench scenarios cover the rest: synchronizer latency, polarity selection, an acknowledge clearing the flag or being ignored depending on the mode, and an acknowledge that coincides with an edge. They also check the combinational wake and pull outputs against random configurations and pin sequences.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_INTEN  = 0;
  localparam int BIT_LEVEL  = 1;
  localparam int BIT_RISING = 2;
  localparam int BIT_PINEN  = 3;
  localparam int BIT_ACK    = 4;
  localparam int BIT_FLAG   = 5;
  localparam int BIT_PIN    = 6;

  typedef struct packed {
    logic pinEn;
    logic risingHigh;
    logic levelMode;
    logic intEn;
    logic ack;
  } irqStrobes_t;
endpackage

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrite,
  input  logic [REG_W-1:0] regWdata,
  input  logic             flag,
  input  logic             pinLevel,
  output irqStrobes_t      strobes,
  output logic [REG_W-1:0] regRdata,
  output logic             irqOut
);
  logic pinEnQ, risingQ, levelQ, intEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinEnQ  <= 1'b0;
      risingQ <= 1'b0;
      levelQ  <= 1'b0;
      intEnQ  <= 1'b0;
    end else if (regWrite) begin
      pinEnQ  <= regWdata[BIT_PINEN];
      risingQ <= regWdata[BIT_RISING];
      levelQ  <= regWdata[BIT_LEVEL];
      intEnQ  <= regWdata[BIT_INTEN];
    end
  end

  always_comb begin
    strobes.pinEn      = pinEnQ;
    strobes.risingHigh = risingQ;
    strobes.levelMode  = levelQ;
    strobes.intEn      = intEnQ;
    strobes.ack        = regWrite & regWdata[BIT_ACK];
  end

  always_comb begin
    regRdata             = '0;
    regRdata[BIT_INTEN]  = intEnQ;
    regRdata[BIT_LEVEL]  = levelQ;
    regRdata[BIT_RISING] = risingQ;
    regRdata[BIT_PINEN]  = pinEnQ;
    regRdata[BIT_FLAG]   = flag;
    regRdata[BIT_PIN]    = pinLevel;
  end

  assign irqOut = flag & intEnQ;

  // R6: a request needs the enable that was written
  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> regRdata[BIT_INTEN]);
endmodule

// File: rtl/extirq_datapath.sv
module extirq_datapath
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinRaw,
  input  logic        stopMode,
  input  irqStrobes_t strobes,
  output logic        flag,
  output logic        pinLevel,
  output logic        wakeOut,
  output logic        pullDown
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinSync, pinPrev;
  logic actNow, actPrev, edgeEv, levelEv, eventHit;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else if (i == 0) syncQ[i] <= pinRaw;
        else syncQ[i] <= syncQ[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign pinSync = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b0;
    else pinPrev <= pinSync;
  end

  // both samples judged with the current polarity, so a polarity change alone is no edge
  assign actNow   = strobes.risingHigh ? pinSync : ~pinSync;
  assign actPrev  = strobes.risingHigh ? pinPrev : ~pinPrev;
  assign edgeEv   = actNow & ~actPrev;
  assign levelEv  = actNow & strobes.levelMode;
  assign eventHit = strobes.pinEn & (edgeEv | levelEv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flag <= 1'b0;
    else if (eventHit) flag <= 1'b1;
    else if (strobes.ack) flag <= 1'b0;
  end

  assign pinLevel = strobes.pinEn & pinSync;
  assign wakeOut  = stopMode & strobes.pinEn & (pinRaw == strobes.risingHigh);
  assign pullDown = strobes.pinEn & strobes.risingHigh;

  // R2: disabled pin never sets a clear flag
  a_r2_no_set_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.pinEn && !flag) |=> !flag);
  // R5: held active level keeps the flag set
  a_r5_level_holds: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pinEn && strobes.levelMode && actNow) |=> flag);
  // R4: an edge-mode rise needs a change between the samples
  a_r4_edge_needs_change: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.levelMode && !flag && strobes.pinEn && pinSync == pinPrev) |=> !flag);
  // R7: acknowledge with nothing enabled clears the flag
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ack && !strobes.pinEn) |=> !flag);
  // R9: wake only in stop mode
  a_r9_wake_in_stop: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> stopMode);
endmodule

// File: rtl/extIrqDetect.sv
module extIrqDetect
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinRaw,
  input  logic             stopMode,
  input  logic             regWrite,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  output logic             irqOut,
  output logic             wakeOut,
  output logic             pullDown
);
  irqStrobes_t strobes;
  logic flag, pinLevel;

  extirq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regWdata(regWdata),
    .flag(flag), .pinLevel(pinLevel), .strobes(strobes),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  extirq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .stopMode(stopMode),
    .strobes(strobes), .flag(flag), .pinLevel(pinLevel),
    .wakeOut(wakeOut), .pullDown(pullDown)
  );

  // R10: pulldown only requested for the enabled pin
  a_r10_pull_enabled: assert property (@(posedge clk) disable iff (!rstN)
    pullDown |-> regRdata[BIT_PINEN]);
endmodule

// File: tb/extIrqDetect_test.sv
module extIrqDetect_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinRaw = 1'b0;
  logic stopMode = 1'b0;
  logic regWrite = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic irqOut, wakeOut, pullDown;
  int checks = 0;
  int errors = 0;

  extIrqDetect uut (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .stopMode(stopMode),
    .regWrite(regWrite), .regWdata(regWdata), .regRdata(regRdata),
    .irqOut(irqOut), .wakeOut(wakeOut), .pullDown(pullDown)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWr(input logic [7:0] d);
    @(negedge clk);
    regWrite = 1'b1; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0; regWdata = '0;
  endtask

  task automatic setPin(input logic v);
    @(negedge clk);
    pinRaw = v;
    waitCyc(4);
  endtask

  // cfg: bit0 intEn, bit1 level mode, bit2 rising/high, bit3 pin enable
  function automatic logic isActive(input logic [3:0] cfg, input logic lvl);
    return lvl == cfg[2];
  endfunction
  function automatic logic flagHeld(input logic [3:0] cfg, input logic lvl);
    return cfg[3] & cfg[1] & isActive(cfg, lvl);
  endfunction
  function automatic logic flagAfter(input logic [3:0] cfg, input logic oldL,
                                     input logic newL, input logic prev);
    if (!cfg[3]) return prev;
    if (newL != oldL && isActive(cfg, newL)) return 1'b1;
    if (cfg[1] && isActive(cfg, newL)) return 1'b1;
    return prev;
  endfunction
  function automatic logic [7:0] expRead(input logic [3:0] cfg, input logic f, input logic lvl);
    return {1'b0, cfg[3] & lvl, f, 1'b0, cfg};
  endfunction

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [3:0] cfg;
    logic oldL, newL, f;
    void'($urandom(32'd2024));
    waitCyc(3);
    // R1 reset state
    check("R1 read", regRdata, 8'h00);
    check("R1 outs", {5'd0, irqOut, wakeOut, pullDown}, 8'h00);
    rstN = 1'b1;
    waitCyc(2);

    // R2 disabled: pin toggles, no flag, pin level reads 0
    regWr(8'h04);
    setPin(1'b1);
    check("R2 disabled read", regRdata, 8'h04);
    setPin(1'b0);

    // R4 edge mode rising: latency of three edges, ack while held clears
    regWr(8'h0D);
    @(negedge clk); pinRaw = 1'b1;
    waitCyc(2);
    check("R4 before third edge", {7'd0, regRdata[5]}, 8'h00);
    waitCyc(1);
    check("R4 set at third edge", {7'd0, regRdata[5]}, 8'h01);
    check("R6 irq on", {7'd0, irqOut}, 8'h01);
    regWr(8'h1D);
    waitCyc(2);
    check("R4 ack clears held", {7'd0, regRdata[5]}, 8'h00);

    // R3 falling polarity: rising edge ignored, falling sets
    regWr(8'h18);
    setPin(1'b0);
    check("R3 falling sets", {7'd0, regRdata[5]}, 8'h01);
    check("R6 no irq without enable", {7'd0, irqOut}, 8'h00);
    regWr(8'h18);
    setPin(1'b1);
    check("R3 rising ignored", {7'd0, regRdata[5]}, 8'h00);

    // R5 level mode: ack ignored while active
    regWr(8'h0E);
    waitCyc(2);
    check("R5 level sets", {7'd0, regRdata[5]}, 8'h01);
    regWr(8'h1E);
    waitCyc(1);
    check("R5 ack ignored while active", {7'd0, regRdata[5]}, 8'h01);
    setPin(1'b0);
    regWr(8'h1E);
    waitCyc(1);
    check("R7 ack clears after level gone", {7'd0, regRdata[5]}, 8'h00);
    setPin(1'b1);
    check("R7 new event sets again", {7'd0, regRdata[5]}, 8'h01);

    // R8 ack on the same edge as a new edge
    setPin(1'b0);
    regWr(8'h1C);
    waitCyc(1);
    check("R8 precondition clear", {7'd0, regRdata[5]}, 8'h00);
    @(negedge clk); pinRaw = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regWrite = 1'b1; regWdata = 8'h1C;
    @(negedge clk);
    regWrite = 1'b0; regWdata = '0;
    check("R8 edge wins", {7'd0, regRdata[5]}, 8'h01);

    // R9 wake and R10 pull select
    regWr(8'h1C);
    stopMode = 1'b1;
    #1 check("R9 wake active", {7'd0, wakeOut}, 8'h01);
    pinRaw = 1'b0;
    #1 check("R9 wake inactive", {7'd0, wakeOut}, 8'h00);
    check("R10 pulldown", {7'd0, pullDown}, 8'h01);
    regWr(8'h08);
    #1 check("R9 wake falling", {7'd0, wakeOut}, 8'h01);
    check("R10 pullup", {7'd0, pullDown}, 8'h00);
    regWr(8'h04);
    pinRaw = 1'b1;
    #1 check("R9 wake disabled", {7'd0, wakeOut}, 8'h00);
    stopMode = 1'b0;
    waitCyc(4);

    // random configurations and pin sequences
    oldL = pinRaw;
    for (int it = 0; it < 200; it++) begin
      cfg = 4'($urandom);
      regWr({4'd0, cfg});
      waitCyc(1);
      regWr({4'b0001, cfg});
      waitCyc(1);
      f = flagHeld(cfg, oldL);
      check("R11 read after ack", regRdata, expRead(cfg, f, oldL));
      newL = 1'($urandom);
      setPin(newL);
      f = flagAfter(cfg, oldL, newL, f);
      check("R5 R4 random flag", regRdata, expRead(cfg, f, newL));
      check("R6 random irq", {7'd0, irqOut}, {7'd0, f & cfg[0]});
      check("R10 random pull", {7'd0, pullDown}, {7'd0, cfg[3] & cfg[2]});
      stopMode = 1'($urandom);
      #1 check("R9 random wake", {7'd0, wakeOut},
               {7'd0, stopMode & cfg[3] & isActive(cfg, newL)});
      stopMode = 1'b0;
      oldL = newL;
    end
    finishRun();
  end
endmodule